// File: doc/BRIEF.md
# Status-First I2C Read Slave

This block is the read side of a two-wire serial slave for a decoder. A read always returns a status byte first. The lowest bit of that byte is a data-available flag. The master may then read one or two data bytes from a pair of output registers. The upstream decoder loads the pair with a single strobe, and that strobe also raises the flag. A read clears the flag only when it reaches the last bit of the first data byte. A read that stops after the status byte leaves the flag unchanged.

The block samples SCL and SDA through synchronisers and detects START and STOP. It collects the address byte and acknowledges one of two read addresses. It then shifts the bytes out MSB first through an open-drain enable. After each byte it samples the master's ACK or NACK. Writes, clock stretching and pad timing are handled elsewhere.

Top module: `i2c_status_rd_slave`

## Requirements
- R1: Until a START arrives (SDA falling while SCL is high), the slave never pulls SDA low, whatever SCL and SDA do.
- R2: The slave changes its SDA drive only while SCL is low.
- R3: The slave acknowledges the address bytes 29h and 2Bh by pulling SDA low during the ninth clock. Any other address byte, including the write forms 28h and 2Ah, gets no acknowledge, and the slave stays released until the next START.
- R4: The first byte after the address carries the data-available flag in bit 0 and status_i[7:1] in bits 7:1. The next byte is data 1 and the byte after it is data 2.
- R5: Every byte is sent MSB first.
- R6: If the master ACKs, the slave sends the next byte, up to three bytes in total. After a NACK the slave releases SDA and ignores further clocks until a START.
- R7: A STOP at any point returns the slave to idle with SDA released.
- R8: The data-available flag clears when the master clocks the eighth bit of data 1.
- R9: A read of the status byte alone never clears the data-available flag.
- R10: A load_i pulse latches data1_i and data2_i and sets the data-available flag. The flag is 0 after reset. If a load and a clear fall in the same cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| load_i | input | 1 | Decoder strobe: latch data and set the flag |
| data1_i | input | 8 | First data byte from the decoder |
| data2_i | input | 8 | Second data byte from the decoder |
| status_i | input | 8 | Status bits; bits 7:1 are sent |
| data_avail_o | output | 1 | Current data-available flag |

## Verification
Reads of one, two and three bytes are run with both addresses. Comparing them shows which read depth clears the flag and in which byte order the data appear. Bus activity before any START, a wrong address, write addresses and extra clocks after a NACK each check that the slave stays released when it should. A STOP in the middle of the status byte checks the return to idle, and a later read checks that the slave recovers. Asymmetric data patterns with a load between reads show the bit order and the reloading of the flag.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_SEND,
    ST_MACK
  } rd_state_t;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_sync[SYNC_STAGES-1];
      sda_d    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_sync[SYNC_STAGES-1];
  assign sda_o      = sda_sync[SYNC_STAGES-1];
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
endmodule

// File: rtl/i2c_avail_reg.sv
module i2c_avail_reg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          clr_i,
  input  logic [DW-1:0] data1_i,
  input  logic [DW-1:0] data2_i,
  output logic [DW-1:0] data1_o,
  output logic [DW-1:0] data2_o,
  output logic          avail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data1_o <= '0;
      data2_o <= '0;
      avail_o <= 1'b0;
    end else begin
      if (load_i) begin
        data1_o <= data1_i;
        data2_o <= data2_i;
      end
      // load has priority over clear
      if (load_i)     avail_o <= 1'b1;
      else if (clr_i) avail_o <= 1'b0;
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> avail_o); // R10
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !load_i) |=> !avail_o); // R8
endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
  import i2c_rd_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          N_BYTES  = 3,
  parameter logic [DW-2:0] ADDR_PRI = 7'h14,
  parameter logic [DW-2:0] ADDR_SEC = 7'h15
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic                       start_i,
  input  logic                       stop_i,
  input  logic                       scl_rise_i,
  input  logic                       scl_fall_i,
  input  logic [N_BYTES-1:0][DW-1:0] tx_bytes_i,
  output logic                       clr_o,
  output logic                       sda_oe_o
);
  localparam int CW = $clog2(DW + 1);
  localparam int IW = (N_BYTES > 2) ? $clog2(N_BYTES) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(N_BYTES - 1);
  localparam logic [IW-1:0] CLR_IDX  = IW'(1);

  rd_state_t     st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [IW-1:0] idx;
  logic          mack;
  logic          addr_hit;

  assign addr_hit = (sh == {ADDR_PRI, 1'b1}) || (sh == {ADDR_SEC, 1'b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      sh   <= '0;
      idx  <= '0;
      mack <= 1'b0;
    end else if (start_i) begin
      st  <= ST_ADDR;
      cnt <= '0;
      idx <= '0;
    end else if (stop_i) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_ADDR: begin
          if (scl_rise_i) begin
            sh  <= {sh[DW-2:0], sda_i};
            cnt <= cnt + 1'b1;
          end else if (scl_fall_i && cnt == CW'(DW)) begin
            st <= addr_hit ? ST_AACK : ST_IDLE;
          end
        end
        ST_AACK: begin
          if (scl_fall_i) begin
            st  <= ST_SEND;
            sh  <= tx_bytes_i[0];
            cnt <= '0;
            idx <= '0;
          end
        end
        ST_SEND: begin
          if (scl_fall_i) begin
            sh <= {sh[DW-2:0], 1'b1};
            if (cnt == CW'(DW - 1)) begin
              st  <= ST_MACK;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) mack <= ~sda_i;
          else if (scl_fall_i) begin
            if (mack && idx != LAST_IDX) begin
              st  <= ST_SEND;
              idx <= idx + 1'b1;
              sh  <= tx_bytes_i[idx + 1'b1];
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // flag clears as the master samples the last bit of data byte 1
  assign clr_o    = (st == ST_SEND) && scl_rise_i && (cnt == CW'(DW - 1)) && (idx == CLR_IDX);
  assign sda_oe_o = (st == ST_AACK) || ((st == ST_SEND) && !sh[DW-1]);

  AST_START_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st == ST_ADDR)); // R1
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (st == ST_IDLE && !sda_oe_o)); // R7
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i); // R2
  AST_ACK_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_AACK) |-> addr_hit); // R3
endmodule

// File: rtl/i2c_status_rd_slave.sv
module i2c_status_rd_slave #(
  parameter int            DW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter logic [DW-2:0] ADDR_PRI    = 7'h14,
  parameter logic [DW-2:0] ADDR_SEC    = 7'h15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          load_i,
  input  logic [DW-1:0] data1_i,
  input  logic [DW-1:0] data2_i,
  input  logic [DW-1:0] status_i,
  output logic          data_avail_o
);
  localparam int N_BYTES = 3;

  logic scl_s, sda_s, start, stop, scl_rise, scl_fall, clr;
  logic [DW-1:0] d1_q, d2_q;
  logic [N_BYTES-1:0][DW-1:0] tx_bytes;

  i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .start_o   (start),
    .stop_o    (stop),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  i2c_avail_reg #(.DW(DW)) u_avail (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .clr_i  (clr),
    .data1_i(data1_i),
    .data2_i(data2_i),
    .data1_o(d1_q),
    .data2_o(d2_q),
    .avail_o(data_avail_o)
  );

  assign tx_bytes = {d2_q, d1_q, {status_i[DW-1:1], data_avail_o}};

  i2c_rd_fsm #(
    .DW      (DW),
    .N_BYTES (N_BYTES),
    .ADDR_PRI(ADDR_PRI),
    .ADDR_SEC(ADDR_SEC)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .start_i   (start),
    .stop_i    (stop),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .tx_bytes_i(tx_bytes),
    .clr_o     (clr),
    .sda_oe_o  (sda_oe_o)
  );
endmodule

// File: tb/tb_i2c_status_rd_slave.sv
module tb_i2c_status_rd_slave;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic load = 1'b0;
  logic [7:0] d1 = '0, d2 = '0, status = 8'hC6;
  logic sda_oe, avail;
  wire  sda_line = sda_m & ~sda_oe;

  int total = 0, bad = 0;
  int r2_viol = 0;
  int oe_seen = 0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;

  // reference model state
  logic       avail_m = 1'b0;
  logic [7:0] d1_m = '0, d2_m = '0;

  always #2 clk = ~clk;

  i2c_status_rd_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .load_i(load), .data1_i(d1), .data2_i(d2), .status_i(status), .data_avail_o(avail)
  );

  // every-clock monitor: drive change while SCL high (R2), any drive (R1)
  always @(negedge clk) begin
    if (rst_n && scl && scl_prev && sda_oe != oe_prev) r2_viol++;
    if (sda_oe) oe_seen++;
    scl_prev = scl;
    oe_prev  = sda_oe;
  end

  task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wt(H);
    scl = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H);
    scl = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wt(H);
    scl = 1'b1; wt(H);
    scl = 1'b0;
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wt(H);
    scl = 1'b1; wt(H / 2);
    b = sda_line; wt(H / 2);
    scl = 1'b0;
  endtask

  task automatic rbyte(output logic [7:0] v);
    logic b;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      rbit(b);
      v = {v[6:0], b};
    end
  endtask

  task automatic send_addr(input logic [7:0] a, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(a[i]);
    rbit(b);
    ack = ~b;
  endtask

  // full read of n bytes; compares each byte with the model
  task automatic rd(input logic [7:0] a, input int n);
    logic ack;
    logic [7:0] v, e;
    bus_start();
    send_addr(a, ack);
    chk(ack == 1'b1, "R3", "address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      e = (i == 0) ? {status[7:1], avail_m} : (i == 1) ? d1_m : d2_m;
      rbyte(v);
      chk(v == e, (i == 0) ? "R4" : "R5", $sformatf("byte %0d", i), v, e);
      wbit(i == n - 1);
    end
    bus_stop();
    if (n >= 2) avail_m = 1'b0;
    chk(avail == avail_m, (n >= 2) ? "R8" : "R9", "flag after read", avail, avail_m);
  endtask

  task automatic do_load(input logic [7:0] a, input logic [7:0] b);
    d1 = a; d2 = b; load = 1'b1; wt(1);
    load = 1'b0; wt(1);
    d1_m = a; d2_m = b; avail_m = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack, b;
    logic [7:0] v;
    wt(3);
    chk(sda_oe == 1'b0, "R1", "reset drive", sda_oe, 0);
    chk(avail == 1'b0, "R10", "reset flag", avail, 0);
    rst_n = 1'b1; wt(4);

    // R1: clocking without START, including a 29h pattern
    scl = 1'b0; wt(H);
    for (int i = 7; i >= 0; i--) wbit(8'h29 >> i);
    v = '0;
    for (int i = 0; i < 9; i++) begin rbit(b); v = {v[6:0], b}; end
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H);
    chk(oe_seen == 0, "R1", "drive before START", oe_seen, 0);

    // R10: load
    do_load(8'hA5, 8'h3C);
    chk(avail == 1'b1, "R10", "flag after load", avail, 1);

    // R9: status only keeps flag
    rd(8'h29, 1);
    rd(8'h29, 1);
    // R8, R4, R5: full read through secondary address
    rd(8'h2B, 3);
    rd(8'h29, 2);

    // R3: wrong and write addresses
    foreach (v[i]) ;
    bus_start(); send_addr(8'hA1, ack);
    chk(ack == 1'b0, "R3", "foreign addr ack", ack, 0);
    rbyte(v);
    chk(v == 8'hFF, "R3", "released after foreign addr", v, 8'hFF);
    bus_stop();
    bus_start(); send_addr(8'h28, ack);
    chk(ack == 1'b0, "R3", "write addr ack", ack, 0);
    bus_stop();

    // R6: NACK then extra clocks
    do_load(8'h81, 8'h7E);
    bus_start(); send_addr(8'h2B, ack);
    rbyte(v);
    chk(v == {status[7:1], 1'b1}, "R6", "status before nack", v, {status[7:1], 1'b1});
    wbit(1'b1);
    rbyte(v);
    chk(v == 8'hFF, "R6", "released after nack", v, 8'hFF);
    bus_stop();
    chk(avail == 1'b1, "R9", "flag after nack on status", avail, 1);

    // R7: STOP inside status byte
    bus_start(); send_addr(8'h29, ack);
    v = '0;
    for (int i = 0; i < 5; i++) begin rbit(b); v = {v[6:0], b}; end
    chk(v[4:0] == 5'b11000, "R7", "partial status bits", v[4:0], 5'b11000);
    bus_stop();
    wt(4);
    chk(sda_oe == 1'b0, "R7", "released after stop", sda_oe, 0);
    scl = 1'b0; wt(H);
    rbyte(v);
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H);
    chk(v == 8'hFF, "R7", "idle after stop", v, 8'hFF);

    // recovery read with new data
    rd(8'h2B, 3);
    status = 8'h5A;
    rd(8'h29, 1);

    chk(r2_viol == 0, "R2", "drive change while SCL high", r2_viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule